// File: doc/BRIEF.md
# Dual-Column Readout Data Multiplexer

This block merges serial hit data from two front-end columns onto a single output line that runs at twice the per-column bit rate. Each column has two redundant input lines (a top and a bottom chip), so the block has four data inputs in all. It captures all four lines once per frame into a holding register and then plays the held bits out one time slot after another. All timing is derived from a single clock and a slot strobe (`slot_ce`) that marks the output bit rate. The block also drives a data-clock level, `dclk_out`, that is high for the first half of every frame.

Static configuration inputs control the block:
- the source of the multiplexer select;
- which redundant line each column uses;
- a quad mode that interleaves all four lines;
- a constant-pattern test mode that makes the output toggle like a clock;
- the sampling phase;
- the readout rate.

Configuration is expected to change only while reset is held.

Top module: `rdmux_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, the unit index is cleared to 0 and the held bits to 0. So `dclk_out` is 1 and `dout` shows the bit for unit 0 of all-zero data. The first frame starts at the first edge after release.
- R2: A unit lasts one `slot_ce` strobe when `cfg_fast`=1 and two strobes when `cfg_fast`=0. A frame is 2 units normally and 4 units when `cfg_quad`=1. `dclk_out` is 1 during the first half of the frame's units and 0 during the second half.
- R3: `dout` and `dclk_out` change only at edges where `slot_ce` is 1. At an edge with `slot_ce`=0 they hold their values.
- R4: With `cfg_samp_inv`=0, `din` is captured at the edge that ends a frame and is shown two frames later. With `cfg_samp_inv`=1, `din` is captured at the mid-frame edge and is shown in the next frame.
- R5: With `cfg_sel`=2'b00, unit 0 carries the column-0 bit and unit 1 carries the column-1 bit.
- R6: With `cfg_sel`=2'b01, unit 0 carries the column-1 bit and unit 1 carries the column-0 bit.
- R7: With `cfg_sel`=2'b10, both units carry the column-0 bit. With `cfg_sel`=2'b11, both units carry the column-1 bit. In these two modes `dout` is steady for the whole frame.
- R8: The column-0 bit is `din[0]`, or `din[2]` when `cfg_col0_alt`=1. The column-1 bit is `din[1]`, or `din[3]` when `cfg_col1_alt`=1.
- R9: With `cfg_const`=1, the column-0 bit is 0 and the column-1 bit is 1 whatever the data. The select still applies, so `cfg_sel`=2'b00 makes `dout` equal to the inverse of `dclk_out`.
- R10: With `cfg_quad`=1, units 0 to 3 carry held `din[0]` to `din[3]` in that order, and `cfg_sel` and the alt bits are ignored. With `cfg_const` also set, units 0 to 3 carry 0,1,0,1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_ce | input | 1 | Output-slot strobe (double-rate clock enable) |
| cfg_sel | input | 2 | Multiplexer select source |
| cfg_col0_alt | input | 1 | Column 0 uses `din[2]` instead of `din[0]` |
| cfg_col1_alt | input | 1 | Column 1 uses `din[3]` instead of `din[1]` |
| cfg_const | input | 1 | Constant-pattern test mode |
| cfg_quad | input | 1 | Interleave all four lines |
| cfg_samp_inv | input | 1 | Capture at mid-frame instead of at frame end |
| cfg_fast | input | 1 | One strobe per unit instead of two |
| din | input | 4 | Front-end data lines |
| dout | output | 1 | Multiplexed serial output |
| dclk_out | output | 1 | Data-clock level, high in the first half of a frame |

## Verification
The hardest situation to reach from the ports is telling the two sampling phases apart. Both phases show the same steady data unless `din` changes inside a frame. The bench therefore aligns itself to frame starts by counting edges from reset release. It then drives one value in the first half of each frame and a different value in the second half. As a result, the expected output in each frame names exactly one earlier half-frame value, which differs between the two phases.

This stimulus is repeated over every combination of the configuration inputs. A separate run gates `slot_ce` in an irregular pattern to expose any output change at an idle edge.

// File: rtl/rdmux_pkg.sv
// Shared types and sizes for the dual-column readout multiplexer.
package rdmux_pkg;
    // Number of front-end data lines (two per column).
    localparam int LANES = 4;
    // Width of the unit index within a frame.
    localparam int IDX_W = $clog2(LANES);

    // Multiplexer select source.
    typedef enum logic [1:0] {
        SEL_DCLK   = 2'b00,
        SEL_DCLK_N = 2'b01,
        SEL_COL0   = 2'b10,
        SEL_COL1   = 2'b11
    } sel_mode_e;
endpackage

// File: rtl/rdmux_timing.sv
// Frame timing generator.
// Divides the slot strobe into units (one or two strobes each) and counts
// units within a frame of two or four. It produces the unit strobe, the
// frame-end strobe, the capture strobe and the data-clock level.
// Assumes the configuration is static while rst_n is high.
module rdmux_timing
    import rdmux_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot_ce,
    input  logic             cfg_fast,
    input  logic             cfg_quad,
    input  logic             cfg_samp_inv,
    output logic             unit_ce,
    output logic             frame_end,
    output logic             samp_stb,
    output logic [IDX_W-1:0] idx,
    output logic             dclk_lvl
);
    localparam logic [IDX_W-1:0] PAIR_LAST = IDX_W'(1);
    localparam logic [IDX_W-1:0] QUAD_LAST = IDX_W'(LANES - 1);

    logic             sub_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] last_idx;
    logic [IDX_W-1:0] half_idx;

    // Derive the frame bounds for the current mode.
    always_comb begin
        last_idx = cfg_quad ? QUAD_LAST : PAIR_LAST;
        half_idx = cfg_quad ? IDX_W'(LANES / 2) : IDX_W'(1);
    end

    // A unit ends on every strobe in fast mode, else on every second strobe.
    assign unit_ce   = slot_ce && (cfg_fast || sub_q);
    assign frame_end = unit_ce && (idx_q == last_idx);
    assign samp_stb  = unit_ce && (cfg_samp_inv ? (idx_q == half_idx - IDX_W'(1))
                                                : (idx_q == last_idx));
    assign dclk_lvl  = (idx_q < half_idx);
    assign idx       = idx_q;

    // Strobe divider for base-rate mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub_q <= 1'b0;
        end else if (slot_ce && !cfg_fast) begin
            sub_q <= ~sub_q;
        end
    end

    // Unit counter within the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (unit_ce) begin
            idx_q <= (idx_q == last_idx) ? '0 : idx_q + IDX_W'(1);
        end
    end

    // R2
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= last_idx);

    // R2
    frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (idx_q == '0));

    // R3
    idle_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_ce |=> $stable(idx_q));
endmodule

// File: rtl/rdmux_capture.sv
// Two-stage sample-and-hold for the data lines.
// Stage one captures din on the capture strobe. Stage two takes stage one at
// every frame end, so the bits played out stay fixed for a whole frame.
module rdmux_capture
    import rdmux_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] din,
    input  logic             samp_stb,
    input  logic             frame_end,
    output logic [LANES-1:0] held
);
    logic [LANES-1:0] stage1_q;
    logic [LANES-1:0] held_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Capture and hold one data line.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage1_q[g] <= 1'b0;
                held_q[g]   <= 1'b0;
            end else begin
                if (samp_stb)  stage1_q[g] <= din[g];
                if (frame_end) held_q[g]   <= stage1_q[g];
            end
        end
    end

    assign held = held_q;

    // R4
    held_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> $stable(held_q));
endmodule

// File: rtl/rdmux_select.sv
// Output bit selection.
// Picks the bit for the current unit from the held lines according to the
// select source, the redundant-line choice, quad mode and constant mode.
// Purely combinational; every input comes from a register or static config.
module rdmux_select
    import rdmux_pkg::*;
(
    input  logic [LANES-1:0] held,
    input  logic [IDX_W-1:0] idx,
    input  logic             dclk_lvl,
    input  logic [1:0]       cfg_sel,
    input  logic             cfg_col0_alt,
    input  logic             cfg_col1_alt,
    input  logic             cfg_const,
    input  logic             cfg_quad,
    output logic             bit_out
);
    sel_mode_e mode;
    logic      col0_bit;
    logic      col1_bit;

    assign mode = sel_mode_e'(cfg_sel);

    // Resolve each column's bit from its chosen line or the test pattern.
    always_comb begin
        col0_bit = cfg_const ? 1'b0 : (cfg_col0_alt ? held[2] : held[0]);
        col1_bit = cfg_const ? 1'b1 : (cfg_col1_alt ? held[3] : held[1]);
    end

    // Choose the bit for the active unit.
    always_comb begin
        if (cfg_quad) begin
            bit_out = cfg_const ? idx[0] : held[idx];
        end else begin
            case (mode)
                SEL_DCLK:   bit_out = dclk_lvl ? col0_bit : col1_bit;
                SEL_DCLK_N: bit_out = dclk_lvl ? col1_bit : col0_bit;
                SEL_COL0:   bit_out = col0_bit;
                default:    bit_out = col1_bit;
            endcase
        end
    end
endmodule

// File: rtl/rdmux_top.sv
// Dual-column readout data multiplexer, top level.
// Wires the frame timing, the two-stage capture and the output selection
// together. The configuration inputs are static outside reset.
module rdmux_top
    import rdmux_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot_ce,
    input  logic [1:0]       cfg_sel,
    input  logic             cfg_col0_alt,
    input  logic             cfg_col1_alt,
    input  logic             cfg_const,
    input  logic             cfg_quad,
    input  logic             cfg_samp_inv,
    input  logic             cfg_fast,
    input  logic [LANES-1:0] din,
    output logic             dout,
    output logic             dclk_out
);
    logic             unit_ce;
    logic             frame_end;
    logic             samp_stb;
    logic [IDX_W-1:0] idx;
    logic             dclk_lvl;
    logic [LANES-1:0] held;

    rdmux_timing timing_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .slot_ce      (slot_ce),
        .cfg_fast     (cfg_fast),
        .cfg_quad     (cfg_quad),
        .cfg_samp_inv (cfg_samp_inv),
        .unit_ce      (unit_ce),
        .frame_end    (frame_end),
        .samp_stb     (samp_stb),
        .idx          (idx),
        .dclk_lvl     (dclk_lvl)
    );

    rdmux_capture capture_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .din       (din),
        .samp_stb  (samp_stb),
        .frame_end (frame_end),
        .held      (held)
    );

    rdmux_select select_i (
        .held         (held),
        .idx          (idx),
        .dclk_lvl     (dclk_lvl),
        .cfg_sel      (cfg_sel),
        .cfg_col0_alt (cfg_col0_alt),
        .cfg_col1_alt (cfg_col1_alt),
        .cfg_const    (cfg_const),
        .cfg_quad     (cfg_quad),
        .bit_out      (dout)
    );

    assign dclk_out = dclk_lvl;

    // R3
    idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_ce |=> ($stable(dout) && $stable(dclk_out)));

    // R9
    const_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_const && !cfg_quad && cfg_sel == SEL_DCLK) |-> (dout == !dclk_out));

    // R7
    fixed_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_quad && cfg_sel[1] && !frame_end) |=> $stable(dout));
endmodule

// File: tb/rdmux_tb_top.sv
// Sweeps every configuration with frame-aligned stimulus, then checks idle strobes.
module rdmux_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       slot_ce;
    logic [1:0] cfg_sel;
    logic       cfg_col0_alt, cfg_col1_alt, cfg_const, cfg_quad, cfg_samp_inv, cfg_fast;
    logic [3:0] din;
    logic       dout, dclk_out;
    int         checks = 0;
    int         fails  = 0;

    always #10 clk = ~clk;

    rdmux_top dut_i (
        .clk(clk), .rst_n(rst_n), .slot_ce(slot_ce), .cfg_sel(cfg_sel),
        .cfg_col0_alt(cfg_col0_alt), .cfg_col1_alt(cfg_col1_alt),
        .cfg_const(cfg_const), .cfg_quad(cfg_quad), .cfg_samp_inv(cfg_samp_inv),
        .cfg_fast(cfg_fast), .din(din), .dout(dout), .dclk_out(dclk_out)
    );

    task automatic chk(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s sel=%0d a0=%0b a1=%0b c=%0b q=%0b inv=%0b f=%0b: got %0b expected %0b",
                     req, cfg_sel, cfg_col0_alt, cfg_col1_alt, cfg_const, cfg_quad,
                     cfg_samp_inv, cfg_fast, act, exp);
        end
    endtask

    function automatic logic [3:0] a_val(input int j);
        return 4'(j * 5 + 3);
    endfunction

    function automatic logic [3:0] b_val(input int j);
        return 4'(j * 11 + 6);
    endfunction

    // Expected bit for unit u given held data h (R5-R10).
    function automatic logic exp_bit(input logic [3:0] h, input int u);
        logic c0, c1;
        if (cfg_quad) return cfg_const ? logic'(u % 2) : h[u];
        c0 = cfg_const ? 1'b0 : (cfg_col0_alt ? h[2] : h[0]);
        c1 = cfg_const ? 1'b1 : (cfg_col1_alt ? h[3] : h[1]);
        case (cfg_sel)
            2'b00:   return (u == 0) ? c0 : c1;
            2'b01:   return (u == 0) ? c1 : c0;
            2'b10:   return c0;
            default: return c1;
        endcase
    endfunction

    function automatic string tag_of();
        if (cfg_quad) return "R10/R4";
        if (cfg_const) return "R9/R4";
        if (cfg_sel == 2'b00) return "R5/R8/R4";
        if (cfg_sel == 2'b01) return "R6/R8/R4";
        return "R7/R8/R4";
    endfunction

    // Reset, then run six frames with a new din value in each half-frame.
    task automatic run_cfg();
        int f_units = cfg_quad ? 4 : 2;
        int u_len   = cfg_fast ? 1 : 2;
        int f_len   = f_units * u_len;
        rst_n = 1'b0; slot_ce = 1'b1; din = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(dout, exp_bit(4'h0, 0), "R1");
        chk(dclk_out, 1'b1, "R1");
        rst_n = 1'b1;
        for (int j = 0; j < 6; j++) begin
            for (int c = 0; c < f_len; c++) begin
                int u = c / u_len;
                logic [3:0] h;
                if (c == 0) din = a_val(j);
                if (c == f_len / 2) din = b_val(j);
                if (cfg_samp_inv) h = (j >= 1) ? a_val(j - 1) : 4'h0;
                else              h = (j >= 2) ? b_val(j - 2) : 4'h0;
                chk(dout, exp_bit(h, u), tag_of());
                chk(dclk_out, logic'(u < f_units / 2), "R2");
                @(posedge clk);
                @(negedge clk);
            end
        end
    endtask

    // R3: irregular strobe gaps must leave the outputs untouched.
    task automatic run_gaps();
        logic prev_d, prev_c, ce;
        rst_n = 1'b0; slot_ce = 1'b1; din = '0;
        cfg_sel = 2'b00; cfg_col0_alt = 0; cfg_col1_alt = 0; cfg_const = 0;
        cfg_quad = 0; cfg_samp_inv = 0; cfg_fast = 1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 300; i++) begin
            ce = ((i * 7) % 5) > 1;
            slot_ce = ce;
            din = 4'(i * 3 + (i >> 2));
            prev_d = dout;
            prev_c = dclk_out;
            @(posedge clk);
            @(negedge clk);
            if (!ce) begin
                chk(dout, prev_d, "R3");
                chk(dclk_out, prev_c, "R3");
            end
        end
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int s = 0; s < 4; s++)
            for (int m = 0; m < 64; m++) begin
                rst_n = 1'b0;
                cfg_sel      = 2'(s);
                cfg_col0_alt = m[0];
                cfg_col1_alt = m[1];
                cfg_const    = m[2];
                cfg_quad     = m[3];
                cfg_samp_inv = m[4];
                cfg_fast     = m[5];
                run_cfg();
            end
        run_gaps();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule